// File: doc/BRIEF.md
# Mode-switchable external interrupt router

The router accepts five external interrupt request lines that have no timing relation to the block clock, plus one on-chip machine-check source. It delivers them to one of two destinations. In normal mode, requests go to a local processor core through a core interrupt output and a core machine-check output. In core-disabled mode, all delivery moves to a single host-facing interrupt output that serves a remote host CPU. In that mode, machine-check goes either to the host-facing output or to a dedicated machine-check pin.

Each request line passes through a two-flop synchronizer. Each line can be programmed as level-sensitive, where the request follows the live synchronized input, or as edge-sensitive, where a rising transition latches a pending bit. Software clears a pending bit by writing a one to it. A per-line mask hides a request from every output without discarding it. Control is held in four registers on a small write and read port:

| Address | Contents |
|---------|----------|
| 0 | Sense |
| 1 | Mask |
| 2 | Control |
| 3 | Pending |

Top module: `ext_irq_router`

## Requirements
- R1: After reset, all four outputs are 0. Reads return: sense (address 0) = 0, mask (address 1) = 5'h1F (all masked), control (address 2) = 0 and pending (address 3) = 0.
- R2: Every request line passes through a two-flop synchronizer. A level change driven between clock edges reaches an output at the third following rising edge and not at the second.
- R3: A line whose sense bit (address 0, bit i) is 0 is level-sensitive and is never latched. Its request follows the synchronized input, and the output falls three edges after the input falls.
- R4: A line whose sense bit is 1 is edge-sensitive. A rising transition of the synchronized input sets pending bit i (address 3, bit i) at the third edge after the change. The output follows one edge later and stays set after the input falls.
- R5: Writing address 3 clears each pending bit whose data bit is 1. If a rising transition of the same line is detected in the cycle of that clear, the bit stays set.
- R6: Mask bit i (address 1, bit i, 1 = masked) stops line i from reaching any output and does not alter its pending bit.
- R7: With control bit 0 = 0 (normal mode), core_irq_o is the OR of the unmasked requests, and host_irq_o and mc_pin_o stay 0.
- R8: With control bit 0 = 1 (core-disabled mode), host_irq_o carries the OR of the unmasked requests, and core_irq_o and core_mc_o stay 0.
- R9: In normal mode, mc_i is forwarded to core_mc_o.
- R10: In core-disabled mode, mc_i drives host_irq_o when control bit 1 = 0, and mc_pin_o when control bit 1 = 1. It acts as a level, and at most one of core_mc_o and mc_pin_o is ever high.
- R11: Outputs are registered. A change of mc_i or of a register value appears on the outputs one rising edge after it is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 5 | Asynchronous external interrupt request lines |
| mc_i | input | 1 | Synchronous machine-check request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 5 | Register write data |
| reg_rdata_o | output | 5 | Register read data (combinational on address) |
| core_irq_o | output | 1 | Interrupt to local core |
| core_mc_o | output | 1 | Machine-check to local core |
| host_irq_o | output | 1 | Host-facing interrupt request |
| mc_pin_o | output | 1 | Dedicated machine-check pin |

## Verification
On every cycle, the assertions check three things about routing. The core outputs stay silent in core-disabled mode, and the host-side outputs stay silent in normal mode. At most one machine-check pin is ever high. They also check that a pending bit is never lost unless it was acknowledged, and that a fully masked set of lines never raises the core interrupt. The exact synchronizer latency, the level-versus-edge difference, the survival of an edge that collides with its own clear, and the unmask and machine-check steering sequences depend on particular stimulus orderings. Only the bench scenarios show these, by comparing against a cycle model on every clock.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  typedef enum logic [1:0] {
    REG_SENSE = 2'd0,
    REG_MASK  = 2'd1,
    REG_CTRL  = 2'd2,
    REG_PEND  = 2'd3
  } reg_addr_e;

  localparam int CTRL_MODE_BIT  = 0;
  localparam int CTRL_MCSEL_BIT = 1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= '0;
    else         chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int WIDTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] sense_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] pend_o,
  output logic [WIDTH-1:0] req_o
);
  logic [WIDTH-1:0] prev_q, pend_q, rise;

  assign rise = sync_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= sync_i;
      // set wins over clear; level lines never hold state
      pend_q <= ((pend_q & ~clr_i) | rise) & sense_i;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_req
    assign req_o[i] = sense_i[i] ? pend_q[i] : sync_i[i];
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_router_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] pend_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [WIDTH-1:0] sense_o,
  output logic [WIDTH-1:0] mask_o,
  output logic             mode_o,
  output logic             mc_sel_o,
  output logic [WIDTH-1:0] clr_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i[WIDTH-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_o  <= '0;
      mask_o   <= '1;
      mode_o   <= 1'b0;
      mc_sel_o <= 1'b0;
    end else if (wr_i) begin
      unique case (reg_addr_e'(addr_i))
        REG_SENSE: sense_o <= wdata_i;
        REG_MASK:  mask_o  <= wdata_i;
        REG_CTRL: begin
          mode_o   <= wdata_i[CTRL_MODE_BIT];
          mc_sel_o <= wdata_i[CTRL_MCSEL_BIT];
        end
        default: ;
      endcase
    end
  end

  assign clr_o = (wr_i && reg_addr_e'(addr_i) == REG_PEND) ? wdata_i : '0;

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      REG_SENSE: rdata_o = sense_o;
      REG_MASK:  rdata_o = mask_o;
      REG_CTRL:  rdata_o = {{(WIDTH-2){1'b0}}, mc_sel_o, mode_o};
      default:   rdata_o = pend_i;
    endcase
  end
endmodule

// File: rtl/ext_irq_router.sv
module ext_irq_router #(
  parameter int NUM_SRC     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               mc_i,
  input  logic               reg_wr_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [NUM_SRC-1:0] reg_rdata_o,
  output logic               core_irq_o,
  output logic               core_mc_o,
  output logic               host_irq_o,
  output logic               mc_pin_o
);
  logic [NUM_SRC-1:0] sync, sense, mask, clr, pend, req;
  logic mode, mc_sel, active;

  irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(irq_i), .q_o(sync)
  );

  irq_capture #(.WIDTH(NUM_SRC)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync), .sense_i(sense),
    .clr_i(clr), .pend_o(pend), .req_o(req)
  );

  irq_regs #(.WIDTH(NUM_SRC)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .pend_i(pend), .rdata_o(reg_rdata_o),
    .sense_o(sense), .mask_o(mask), .mode_o(mode), .mc_sel_o(mc_sel),
    .clr_o(clr)
  );

  assign active = |(req & ~mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_irq_o <= 1'b0;
      core_mc_o  <= 1'b0;
      host_irq_o <= 1'b0;
      mc_pin_o   <= 1'b0;
    end else begin
      core_irq_o <= !mode && active;
      core_mc_o  <= !mode && mc_i;
      host_irq_o <= mode && (active || (mc_i && !mc_sel));
      mc_pin_o   <= mode && mc_i && mc_sel;
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_SRC = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mode,
  input logic [NUM_SRC-1:0] mask,
  input logic [NUM_SRC-1:0] sense,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] clr,
  input logic               core_irq_o,
  input logic               core_mc_o,
  input logic               host_irq_o,
  input logic               mc_pin_o
);
  assert_core_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode |=> (!core_irq_o && !core_mc_o));

  assert_host_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode |=> (!host_irq_o && !mc_pin_o));

  assert_mc_one_pin_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({core_mc_o, mc_pin_o}));

  assert_pend_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(pend) & ~$past(clr) & $past(sense)) & ~pend) == '0));

  assert_all_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask) |=> !core_irq_o);
endmodule

bind ext_irq_router irq_router_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode(mode), .mask(mask), .sense(sense),
  .pend(pend), .clr(clr), .core_irq_o(core_irq_o), .core_mc_o(core_mc_o),
  .host_irq_o(host_irq_o), .mc_pin_o(mc_pin_o)
);

// File: tb/sim_ext_irq_router.sv
module sim_ext_irq_router;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic mc = 1'b0;
  logic wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic core_irq, core_mc, host_irq, mc_pin;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ext_irq_router u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .mc_i(mc),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .core_irq_o(core_irq), .core_mc_o(core_mc),
    .host_irq_o(host_irq), .mc_pin_o(mc_pin)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: input history, latched edges, register copy
  logic [N-1:0] h1, h2, h3, m_sense, m_mask, m_pend;
  logic m_mode, m_sel, m_core, m_cmc, m_host, m_pin;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 = '0; h2 = '0; h3 = '0;
      m_sense = '0; m_mask = '1; m_pend = '0;
      m_mode = 0; m_sel = 0;
      m_core = 0; m_cmc = 0; m_host = 0; m_pin = 0;
    end else begin
      logic any;
      logic [N-1:0] clrv;
      any = 0;
      for (int i = 0; i < N; i++)
        if (!m_mask[i] && (m_sense[i] ? m_pend[i] : h2[i])) any = 1;
      m_core = !m_mode && any;
      m_cmc  = !m_mode && mc;
      m_host = m_mode && (any || (mc && !m_sel));
      m_pin  = m_mode && mc && m_sel;
      clrv = (wr && addr == 2'd3) ? wdata : '0;
      for (int i = 0; i < N; i++) begin
        if (!m_sense[i]) m_pend[i] = 0;
        else if (h2[i] && !h3[i]) m_pend[i] = 1;
        else if (clrv[i]) m_pend[i] = 0;
      end
      if (wr) begin
        if (addr == 2'd0) m_sense = wdata;
        if (addr == 2'd1) m_mask = wdata;
        if (addr == 2'd2) begin m_mode = wdata[0]; m_sel = wdata[1]; end
      end
      h3 = h2; h2 = h1; h1 = irq;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 core_irq_o vs model", core_irq, m_core);
      chk("R8 host_irq_o vs model", host_irq, m_host);
      chk("R9 core_mc_o vs model", core_mc, m_cmc);
      chk("R10 mc_pin_o vs model", mc_pin, m_pin);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [N-1:0] d);
    wr = 1; addr = a; wdata = d;
    tick(1);
    wr = 0;
  endtask

  task automatic rreg(input logic [1:0] a, input int exp, input string tag);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    // R1 reset state
    chk("R1 outputs idle", {core_irq, core_mc, host_irq, mc_pin}, 0);
    rreg(2'd0, 0, "R1 sense reset");
    rreg(2'd1, 5'h1F, "R1 mask reset");
    rreg(2'd2, 0, "R1 ctrl reset");
    rreg(2'd3, 0, "R1 pend reset");
    tick(1);

    // R2 R3 level line 0
    wreg(2'd1, 5'h00);
    irq[0] = 1;
    tick(2); chk("R2 not yet at edge 2", core_irq, 0);
    tick(1); chk("R2 R3 level seen at edge 3", core_irq, 1);
    rreg(2'd3, 0, "R3 level not latched");
    irq[0] = 0;
    tick(2); chk("R3 still high at edge 2", core_irq, 1);
    tick(1); chk("R3 follows drop", core_irq, 0);

    // R4 edge line 2, one-cycle pulse
    wreg(2'd0, 5'b00100);
    irq[2] = 1; tick(1); irq[2] = 0;
    tick(2);
    rreg(2'd3, 5'b00100, "R4 pending set");
    chk("R4 output one edge later", core_irq, 0);
    tick(1); chk("R4 output asserted", core_irq, 1);
    tick(4); chk("R4 held after input low", core_irq, 1);

    // R5 clear
    wreg(2'd3, 5'b00100);
    tick(1); chk("R5 cleared output", core_irq, 0);
    rreg(2'd3, 0, "R5 pending cleared");

    // R5 collision: pending set, then clear in the cycle of a new edge
    irq[2] = 1; tick(3); irq[2] = 0; tick(3);
    rreg(2'd3, 5'b00100, "R5 re-pending");
    irq[2] = 1; tick(2);
    wreg(2'd3, 5'b00100);
    rreg(2'd3, 5'b00100, "R5 edge beats clear");
    irq[2] = 0;
    tick(1); chk("R5 output kept", core_irq, 1);

    // R6 mask keeps pending
    wreg(2'd1, 5'b00100);
    tick(1); chk("R6 masked output", core_irq, 0);
    rreg(2'd3, 5'b00100, "R6 pending kept");
    wreg(2'd1, 5'h00);
    tick(1); chk("R6 R11 unmask", core_irq, 1);

    // R8 core-disabled mode
    wreg(2'd2, 5'b00001);
    rreg(2'd2, 1, "R8 ctrl readback");
    tick(1);
    chk("R8 host carries", host_irq, 1);
    chk("R8 core forced off", core_irq, 0);
    wreg(2'd3, 5'h1F);
    tick(1); chk("R8 host drops", host_irq, 0);

    // R10 machine-check steering
    mc = 1;
    tick(1);
    chk("R10 mc on host", host_irq, 1);
    chk("R10 pin idle", mc_pin, 0);
    chk("R8 core mc off", core_mc, 0);
    wreg(2'd2, 5'b00011);
    tick(1);
    chk("R10 mc on pin", mc_pin, 1);
    chk("R10 host idle", host_irq, 0);

    // R9 R11 normal mode machine-check
    wreg(2'd2, 5'b00000);
    tick(1);
    chk("R9 core mc", core_mc, 1);
    chk("R7 pin idle", mc_pin, 0);
    mc = 0;
    tick(1); chk("R11 mc drop one edge", core_mc, 0);

    // R7 level on line 4 in normal mode
    irq[4] = 1; tick(3);
    chk("R7 core from line 4", core_irq, 1);
    chk("R7 host idle", host_irq, 0);
    irq[4] = 0; tick(4);

    done = 1;
    summary();
    $finish;
  end
endmodule